// File: doc/BRIEF.md
# Posted Write Buffer

This block sits between a write-through cache and a slow main memory. Every CPU store produces one entry in a small first-in first-out queue, whether it hit or missed in the cache. The store is acknowledged as soon as its entry is captured, so the CPU can move on while the queue empties itself into memory in the background, one transaction at a time.

A cache read miss is presented on a separate lookup port. The most recent queued value for that address is returned straight from the queue when one exists. Otherwise the memory read is held back until every queued store has reached memory, so a load never overtakes an older store.

The memory port uses one request and acknowledge handshake for both stores and loads. A request and its address, data and direction stay fixed until the memory acknowledges.

Top module: `posted_wbuf`

## Requirements
- R1: During and right after reset, `wr_ack`, `rd_done` and `mem_req` are low and the queue is empty. A first read miss then goes to memory.
- R2: A store held on `wr_valid` while fewer than DEPTH (default 4) entries are queued and no read is pending is stored at the next clock edge. `wr_ack` is high for exactly the following cycle, without waiting for memory.
- R3: With DEPTH entries queued, `wr_ack` is withheld until an entry has drained to memory. The queue never holds more than DEPTH entries.
- R4: Entries drain in arrival order. Each drain is one request with `mem_we`=1 whose address and data stay stable until `mem_ack`.
- R5: A read whose address matches a queued entry completes one cycle after it is presented. `rd_fwd`=1 and `rd_data` carries the newest matching store, and no memory read is issued.
- R6: A read with no match issues a memory read (`mem_we`=0) only once the queue is empty. `rd_done` rises the cycle after `mem_ack`, carrying `mem_rdata`, with `rd_fwd`=0.
- R7: A store accepted in the same cycle that an entry drains is kept. The fill count stays exact and memory ends equal to the CPU's view of it.
- R8: While a read is pending, store acceptance is held off until the read completes.
- R9: Stores are never merged. Repeated stores to one address each produce their own memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Store request, held until `wr_ack` |
| wr_addr | input | AW | Store address |
| wr_data | input | DW | Store data |
| wr_ack | output | 1 | One-cycle pulse: store captured |
| rd_req | input | 1 | Read-miss request, held until `rd_done` |
| rd_addr | input | AW | Read-miss address |
| rd_done | output | 1 | One-cycle pulse: read result valid |
| rd_data | output | DW | Read result |
| rd_fwd | output | 1 | Result came from the queue |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_ack | input | 1 | Memory completion pulse |
| mem_rdata | input | DW | Memory read data, valid with `mem_ack` |

## Verification
Directed runs with the memory stalled fill the queue one store at a time. They separate the one-cycle acknowledge from the withheld acknowledge at full occupancy. Two stores to one address, followed by a read of it, show whether forwarding picks the newest entry or the oldest. A non-matching read issued against a stalled, non-empty queue, with a store raised behind it, shows whether the load waits for the drain and whether the store waits for the load. A long random mix over a narrow address range with varying memory latency exercises drains that coincide with accepted stores. It compares every read and the final memory image against a reference view.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  typedef enum logic [1:0] {
    MS_IDLE  = 2'd0,
    MS_WRITE = 2'd1,
    MS_READ  = 2'd2
  } mem_state_e;
endpackage

// File: rtl/wbuf_fifo.sv
// Entry storage and occupancy tracking. DEPTH must be a power of two >= 2.
module wbuf_fifo #(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           push,
  input  logic [AW-1:0]                  push_addr,
  input  logic [DW-1:0]                  push_data,
  input  logic                           pop,
  output logic [AW-1:0]                  head_addr,
  output logic [DW-1:0]                  head_data,
  output logic [$clog2(DEPTH)-1:0]       head_ptr,
  output logic [$clog2(DEPTH+1)-1:0]     fill,
  output logic                           full,
  output logic                           empty,
  output logic [DEPTH-1:0][AW-1:0]       slot_addr,
  output logic [DEPTH-1:0][DW-1:0]       slot_data
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] fill_q;
  logic [DEPTH-1:0][AW-1:0] addr_q;
  logic [DEPTH-1:0][DW-1:0] data_q;

  // storage carries no reset: only occupied slots are ever read
  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[wr_ptr_q] <= push_addr;
      data_q[wr_ptr_q] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      fill_q   <= '0;
    end else begin
      if (push) wr_ptr_q <= wr_ptr_q + PW'(1);
      if (pop)  rd_ptr_q <= rd_ptr_q + PW'(1);
      case ({push, pop})
        2'b10:   fill_q <= fill_q + CW'(1);
        2'b01:   fill_q <= fill_q - CW'(1);
        default: fill_q <= fill_q;
      endcase
    end
  end

  assign head_addr = addr_q[rd_ptr_q];
  assign head_data = data_q[rd_ptr_q];
  assign head_ptr  = rd_ptr_q;
  assign fill      = fill_q;
  assign full      = (fill_q == CW'(DEPTH));
  assign empty     = (fill_q == '0);
  assign slot_addr = addr_q;
  assign slot_data = data_q;
endmodule

// File: rtl/wbuf_match.sv
// Finds the newest occupied entry whose address equals the read-miss address.
module wbuf_match #(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input  logic [DEPTH-1:0][AW-1:0]   slot_addr,
  input  logic [DEPTH-1:0][DW-1:0]   slot_data,
  input  logic [$clog2(DEPTH)-1:0]   head_ptr,
  input  logic [$clog2(DEPTH+1)-1:0] fill,
  input  logic [AW-1:0]              look_addr,
  output logic                       hit,
  output logic [DW-1:0]              hit_data
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  // walk from oldest to newest; a later match overrides an earlier one
  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    for (int age = 0; age < DEPTH; age++) begin
      logic [PW-1:0] idx;
      idx = head_ptr + PW'(age);
      if ((CW'(age) < fill) && (slot_addr[idx] == look_addr)) begin
        hit      = 1'b1;
        hit_data = slot_data[idx];
      end
    end
  end
endmodule

// File: rtl/wbuf_memport.sv
// Memory-side sequencer: drains queued stores first, then serves a pending read.
module wbuf_memport
  import wbuf_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          q_empty,
  input  logic [AW-1:0] head_addr,
  input  logic [DW-1:0] head_data,
  input  logic          rd_go,
  input  logic [AW-1:0] rd_addr,
  input  logic          mem_ack,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          pop,
  output logic          rd_fill
);
  mem_state_e state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= MS_IDLE;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      case (state_q)
        MS_IDLE: begin
          if (!q_empty) begin
            state_q   <= MS_WRITE;
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= head_addr;
            mem_wdata <= head_data;
          end else if (rd_go) begin
            state_q  <= MS_READ;
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= rd_addr;
          end
        end
        MS_WRITE, MS_READ: begin
          if (mem_ack) begin
            state_q <= MS_IDLE;
            mem_req <= 1'b0;
          end
        end
        default: state_q <= MS_IDLE;
      endcase
    end
  end

  assign pop     = (state_q == MS_WRITE) && mem_ack;
  assign rd_fill = (state_q == MS_READ) && mem_ack;
endmodule

// File: rtl/posted_wbuf.sv
module posted_wbuf #(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ack,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_done,
  output logic [DW-1:0] rd_data,
  output logic          rd_fwd,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic                     push, pop, rd_fill;
  logic                     q_full, q_empty;
  logic [CW-1:0]            fill_cnt;
  logic [PW-1:0]            head_ptr;
  logic [AW-1:0]            head_addr;
  logic [DW-1:0]            head_data;
  logic [DEPTH-1:0][AW-1:0] slot_addr;
  logic [DEPTH-1:0][DW-1:0] slot_data;
  logic                     hit;
  logic [DW-1:0]            hit_data;
  logic                     rd_open, fwd_take, rd_go;
  logic                     wr_ack_q, rd_done_q, rd_fwd_q;
  logic [DW-1:0]            rd_data_q;

  // a read is open from presentation until its result pulse
  assign rd_open  = rd_req && !rd_done_q;
  assign fwd_take = rd_open && hit;
  assign rd_go    = rd_open && !hit && q_empty;
  // stores wait while a read is pending, and when the queue is full
  assign push     = wr_valid && !wr_ack_q && !q_full && !rd_req;

  wbuf_fifo #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .push_addr (wr_addr),
    .push_data (wr_data),
    .pop       (pop),
    .head_addr (head_addr),
    .head_data (head_data),
    .head_ptr  (head_ptr),
    .fill      (fill_cnt),
    .full      (q_full),
    .empty     (q_empty),
    .slot_addr (slot_addr),
    .slot_data (slot_data)
  );

  wbuf_match #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_match (
    .slot_addr (slot_addr),
    .slot_data (slot_data),
    .head_ptr  (head_ptr),
    .fill      (fill_cnt),
    .look_addr (rd_addr),
    .hit       (hit),
    .hit_data  (hit_data)
  );

  wbuf_memport #(.AW(AW), .DW(DW)) u_memport (
    .clk       (clk),
    .rst       (rst),
    .q_empty   (q_empty),
    .head_addr (head_addr),
    .head_data (head_data),
    .rd_go     (rd_go),
    .rd_addr   (rd_addr),
    .mem_ack   (mem_ack),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .pop       (pop),
    .rd_fill   (rd_fill)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ack_q  <= 1'b0;
      rd_done_q <= 1'b0;
      rd_fwd_q  <= 1'b0;
      rd_data_q <= '0;
    end else begin
      wr_ack_q  <= push;
      rd_done_q <= fwd_take || rd_fill;
      rd_fwd_q  <= fwd_take;
      if (fwd_take)     rd_data_q <= hit_data;
      else if (rd_fill) rd_data_q <= mem_rdata;
    end
  end

  assign wr_ack  = wr_ack_q;
  assign rd_done = rd_done_q;
  assign rd_fwd  = rd_fwd_q;
  assign rd_data = rd_data_q;
endmodule

// File: rtl/posted_wbuf_chk.sv
module posted_wbuf_chk #(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       wr_ack,
  input logic                       rd_req,
  input logic                       rd_done,
  input logic                       rd_fwd,
  input logic                       mem_req,
  input logic                       mem_we,
  input logic [AW-1:0]              mem_addr,
  input logic [DW-1:0]              mem_wdata,
  input logic                       mem_ack,
  input logic                       push,
  input logic                       pop,
  input logic [$clog2(DEPTH+1)-1:0] fill
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!mem_req && !wr_ack && !rd_done && fill == '0));

  // R2
  wr_ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wr_ack |=> !wr_ack);

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> (int'(fill) < DEPTH));

  // R4
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

  // R5
  fwd_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    rd_fwd |-> rd_done);

  // R6
  read_after_drain_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |-> (fill == '0));

  // R7
  fill_track_chk: assert property (@(posedge clk) disable iff (rst)
    int'(fill) == int'($past(fill)) + int'($past(push)) - int'($past(pop)));

  // R8
  no_store_in_read_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> !rd_req);
endmodule

bind posted_wbuf posted_wbuf_chk #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_ack    (wr_ack),
  .rd_req    (rd_req),
  .rd_done   (rd_done),
  .rd_fwd    (rd_fwd),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack),
  .push      (push),
  .pop       (pop),
  .fill      (fill_cnt)
);

// File: tb/posted_wbuf_bench.sv
module posted_wbuf_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int DEPTH = 4;
  localparam int NMEM = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic wr_ack;
  logic rd_req = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic rd_done, rd_fwd;
  logic [DW-1:0] rd_data;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic mem_ack = 1'b0;
  logic [DW-1:0] mem_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  posted_wbuf #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_posted_wbuf (
    .clk(clk), .rst(rst),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_done(rd_done), .rd_data(rd_data), .rd_fwd(rd_fwd),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int n_cpuwr = 0;
  int n_memwr = 0;
  int n_memrd = 0;
  bit stall = 1'b0;
  logic [DW-1:0] ref_mem [NMEM];
  logic [DW-1:0] main_mem [NMEM];
  logic [AW+DW-1:0] exp_q [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] init_word(input int a);
    return DW'(a * 3 + 16'h0100);
  endfunction

  // memory model: acknowledges after a random wait unless stalled
  initial begin
    int wait_cnt = 0;
    int lat = 1;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
      end else if (mem_req && !stall && !rst) begin
        if (wait_cnt < lat) begin
          wait_cnt++;
        end else begin
          wait_cnt = 0;
          lat = $urandom_range(0, 3);
          mem_ack = 1'b1;
          if (mem_we) begin
            // R4 drain order and content
            if (exp_q.size() == 0) begin
              check(1'b0, "R4", "write with nothing queued", mem_addr, 0);
            end else begin
              check({mem_addr, mem_wdata} == exp_q[0], "R4", "drain order",
                    {mem_addr, mem_wdata}, exp_q[0]);
              void'(exp_q.pop_front());
            end
            main_mem[mem_addr] = mem_wdata;
            n_memwr++;
          end else begin
            // R6 read only after queue emptied
            check(exp_q.size() == 0, "R6", "read with stores queued", exp_q.size(), 0);
            mem_rdata = main_mem[mem_addr];
            n_memrd++;
          end
        end
      end
    end
  end

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          output int lat, output int at_cyc);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!wr_ack && lat < 3000);
    wr_valid = 1'b0;
    at_cyc = cyc;
    if (wr_ack) begin
      ref_mem[a] = d;
      exp_q.push_back({a, d});
      n_cpuwr++;
    end
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] d,
                         output bit fwd, output int lat, output int at_cyc);
    @(negedge clk);
    rd_req = 1'b1; rd_addr = a;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!rd_done && lat < 3000);
    d = rd_data; fwd = rd_fwd;
    rd_req = 1'b0;
    at_cyc = cyc;
  endtask

  initial begin
    int lat, wc, rc, memrd0;
    logic [DW-1:0] d;
    bit fwd;
    bit rd_finished;
    void'($urandom(32'h5eed_0417));
    for (int i = 0; i < NMEM; i++) begin
      ref_mem[i] = init_word(i);
      main_mem[i] = init_word(i);
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!wr_ack && !rd_done && !mem_req, "R1", "outputs in reset",
          {wr_ack, rd_done, mem_req}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!wr_ack && !rd_done && !mem_req, "R1", "outputs after reset",
          {wr_ack, rd_done, mem_req}, 0);
    do_read(8'd3, d, fwd, lat, rc);
    check(d == init_word(3) && !fwd, "R1", "first read from memory", {fwd, d}, init_word(3));

    // R2 immediate acknowledge with memory stalled; R9 same address twice
    stall = 1'b1;
    do_write(8'd5, 16'h0011, lat, wc);
    check(lat == 1, "R2", "ack latency 1st", lat, 1);
    do_write(8'd5, 16'h0022, lat, wc);
    check(lat == 1, "R2", "ack latency 2nd", lat, 1);
    do_write(8'd9, 16'h0033, lat, wc);
    check(lat == 1, "R2", "ack latency 3rd", lat, 1);
    // R5 newest matching entry forwarded, no memory read
    memrd0 = n_memrd;
    do_read(8'd5, d, fwd, lat, rc);
    check(fwd && d == 16'h0022, "R5", "forward newest", {fwd, d}, {1'b1, 16'h0022});
    check(lat == 1, "R5", "forward latency", lat, 1);
    check(n_memrd == memrd0, "R5", "memory reads during forward", n_memrd, memrd0);
    do_write(8'd12, 16'h0044, lat, wc);
    check(lat == 1, "R2", "ack latency 4th", lat, 1);
    // R3 full queue withholds acknowledge until a drain
    fork
      do_write(8'd13, 16'h0055, lat, wc);
      begin repeat (8) @(negedge clk); stall = 1'b0; end
    join
    check(lat > 8, "R3", "ack withheld while full", lat, 9);

    // R6 / R8 non-matching read behind a stalled non-empty queue
    stall = 1'b1;
    do_write(8'd20, 16'h0066, lat, wc);
    rd_finished = 1'b0;
    memrd0 = n_memrd;
    fork
      begin do_read(8'd7, d, fwd, lat, rc); rd_finished = 1'b1; end
      begin repeat (2) @(negedge clk); do_write(8'd21, 16'h0077, lat, wc); end
      begin
        repeat (10) @(negedge clk);
        check(!rd_finished, "R6", "read done before drain", rd_finished, 0);
        check(n_memrd == memrd0, "R6", "memory read while queue busy", n_memrd, memrd0);
        stall = 1'b0;
      end
    join
    check(!fwd && d == init_word(7), "R6", "read via memory", {fwd, d}, init_word(7));
    check(wc > rc, "R8", "store accepted after read", wc, rc + 1);

    // random mix: R5 R6 R7 data against reference view
    for (int k = 0; k < 400; k++) begin
      logic [AW-1:0] a;
      a = AW'($urandom_range(0, 15));
      if ($urandom_range(0, 2) != 0) begin
        do_write(a, DW'($urandom), lat, wc);
      end else begin
        do_read(a, d, fwd, lat, rc);
        check(d == ref_mem[a], "R5 R6", "random read data", d, ref_mem[a]);
      end
    end

    repeat (60) @(negedge clk);
    // R7 final memory image and queue drained
    begin
      int bad = 0;
      for (int i = 0; i < NMEM; i++) if (main_mem[i] !== ref_mem[i]) bad++;
      check(bad == 0, "R7", "memory words differing", bad, 0);
    end
    check(exp_q.size() == 0, "R7", "stores left undrained", exp_q.size(), 0);
    // R9 one memory write per store
    check(n_memwr == n_cpuwr, "R9", "memory write count", n_memwr, n_cpuwr);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule